// File: doc/BRIEF.md
# Key Event Queue With Live Hold Timer

This block keeps a short history of key events for a host that services them at its own pace. Each slot stores a key code and a duration byte. The newest slot is the live one. Its duration keeps counting in place, one step per timebase tick, until the next event closes it. Closing freezes that duration and opens a fresh live slot with a zero count. All other slots are closed records that wait to be read.

The host sees the slot under the read pointer on two output buses at all times. A read-request strobe acknowledges the active-low interrupt. A separate advance strobe consumes a closed slot. Advancing is ignored when only the live slot remains. In that state the host keeps seeing the live key and its running duration.

When every slot is occupied, a new event overwrites the oldest record. A synchronous clear returns every slot and both pointers to their idle values, the same as reset.

Top module: `key_event_fifo`

## Requirements
- R1: After reset, every slot holds key 0xFF and duration 0x00. `empty` is 1, `int_n` is 1, and the outputs show key 0xFF with duration 0x00.
- R2: Each `tick` pulse without an event raises the live slot's 7-bit count (duration bits 6:0) by one.
- R3: A tick while the count is 127 sets duration bit 7 and wraps the count to 0. Bit 7 then stays set while the count keeps running, until the slot is reloaded or cleared.
- R4: An event closes the live slot with its duration frozen. The next slot becomes live with the new key and duration 0x00. One cycle later `int_n` is 0 and `empty` is 0.
- R5: `rd_req` drives `int_n` to 1 on the next cycle. If an event arrives in the same cycle, `int_n` stays 0 instead.
- R6: `adv_req` with a closed slot under the read pointer moves the pointer to the next slot. `adv_req` while `empty` is 1 is ignored, and the live slot stays on the outputs.
- R7: An event that arrives while every other slot holds a closed record overwrites the oldest record. The read pointer moves to the next-oldest record.
- R8: Both pointers wrap from the last slot to slot 0.
- R9: `rd_key`/`rd_dur` always show the slot under the read pointer. A closed slot's duration does not change with ticks.
- R10: `pd_clear` gives the same state as R1 on the next cycle, whatever the prior state, and has priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_clear | input | 1 | Synchronous clear to the idle state |
| evt_valid | input | 1 | One-cycle strobe: a debounced key event |
| evt_code | input | KEY_W | Key code of the event |
| tick | input | 1 | One-cycle timebase pulse (32 ms period) |
| rd_req | input | 1 | Host read of the current slot; acknowledges the interrupt |
| adv_req | input | 1 | Host request to consume the slot under the read pointer |
| rd_key | output | KEY_W | Key code of the slot under the read pointer |
| rd_dur | output | CNT_W+1 | Duration of that slot: bit 7 overflow, bits 6:0 count |
| empty | output | 1 | No closed slots remain; the read pointer is on the live slot |
| int_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `evt_valid`, `tick`, `rd_req`, `adv_req` and `pd_clear` are single-cycle strobes. They also assume these inputs are driven to known values from time zero. The bench drives every strobe for exactly one clock, changing it on the falling edge. Strobes are combined only where a requirement calls for it, as with an event together with a read request. The stability checks on the outputs only apply in cycles with no event, tick, advance or clear. The directed scenarios therefore leave idle cycles in which those properties are exercised.

// File: rtl/kef_pkg.sv
package kef_pkg;

   // Per-slot action chosen each cycle by the store
   typedef enum logic [1:0] {
      SLOT_HOLD  = 2'd0,
      SLOT_LOAD  = 2'd1,
      SLOT_COUNT = 2'd2,
      SLOT_IDLE  = 2'd3
   } slot_op_e;

   // Next index on a circular range of the given size
   function automatic int unsigned ring_next(input int unsigned idx,
                                             input int unsigned size);
      return (idx == size - 1) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/kef_dur_step.sv
module kef_dur_step #(
   parameter int CNT_W = 7,
   localparam int DUR_W = CNT_W + 1
) (
   input  logic [DUR_W-1:0] cur,
   output logic [DUR_W-1:0] nxt
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic             ovf;
   logic             at_top;

   assign cnt     = cur[CNT_W-1:0];
   assign ovf     = cur[CNT_W];
   assign at_top  = &cnt;
   assign cnt_inc = cnt + CNT_W'(1);
   assign nxt     = {ovf | at_top, cnt_inc};
endmodule

// File: rtl/kef_ptr_ctrl.sv
module kef_ptr_ctrl #(
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             evt,
   input  logic             adv,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] wr_nxt,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             empty
);
   import kef_pkg::*;

   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] wr_q, rd_q, rd_nxt;
   logic             full;

   assign wr_nxt = (wr_q == LAST) ? '0 : wr_q + PTR_W'(1);
   assign rd_nxt = (rd_q == LAST) ? '0 : rd_q + PTR_W'(1);
   assign full   = (wr_nxt == rd_q);
   assign empty  = (wr_q == rd_q);
   assign wr_ptr = wr_q;
   assign rd_ptr = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else if (clr) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (evt) begin
            wr_q <= wr_nxt;
         end
         if (evt && full) begin
            rd_q <= rd_nxt;            // oldest record overwritten
         end else if (adv && !empty) begin
            rd_q <= rd_nxt;            // consume one closed record
         end
      end
   end
endmodule

// File: rtl/kef_slot_store.sv
module kef_slot_store #(
   parameter int             DEPTH    = 8,
   parameter int             KEY_W    = 8,
   parameter int             CNT_W    = 7,
   parameter logic [KEY_W-1:0] KEY_IDLE = '1,
   localparam int            DUR_W    = CNT_W + 1,
   localparam int            PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             evt,
   input  logic [KEY_W-1:0] evt_code,
   input  logic             tick,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [PTR_W-1:0] wr_nxt,
   input  logic [PTR_W-1:0] rd_ptr,
   input  logic [DUR_W-1:0] live_dur_nxt,
   output logic [DUR_W-1:0] live_dur,
   output logic [KEY_W-1:0] rd_key,
   output logic [DUR_W-1:0] rd_dur
);
   import kef_pkg::*;

   logic [KEY_W-1:0] key_w [DEPTH];
   logic [DUR_W-1:0] dur_w [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      slot_op_e         op;
      logic [KEY_W-1:0] key_r;
      logic [DUR_W-1:0] dur_r;

      always_comb begin
         if (clr)
            op = SLOT_IDLE;
         else if (evt && (wr_nxt == PTR_W'(i)))
            op = SLOT_LOAD;
         else if (!evt && tick && (wr_ptr == PTR_W'(i)))
            op = SLOT_COUNT;
         else
            op = SLOT_HOLD;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            key_r <= KEY_IDLE;
            dur_r <= '0;
         end else begin
            unique case (op)
               SLOT_IDLE: begin
                  key_r <= KEY_IDLE;
                  dur_r <= '0;
               end
               SLOT_LOAD: begin
                  key_r <= evt_code;
                  dur_r <= '0;
               end
               SLOT_COUNT: dur_r <= live_dur_nxt;
               default: ;
            endcase
         end
      end

      assign key_w[i] = key_r;
      assign dur_w[i] = dur_r;
   end

   assign live_dur = dur_w[wr_ptr];
   assign rd_key   = key_w[rd_ptr];
   assign rd_dur   = dur_w[rd_ptr];
endmodule

// File: rtl/kef_irq.sv
module kef_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic evt,
   input  logic ack,
   output logic int_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         int_n <= 1'b1;
      else if (clr)
         int_n <= 1'b1;
      else if (evt)
         int_n <= 1'b0;
      else if (ack)
         int_n <= 1'b1;
   end
endmodule

// File: rtl/key_event_fifo.sv
module key_event_fifo #(
   parameter int               DEPTH    = 8,
   parameter int               KEY_W    = 8,
   parameter int               CNT_W    = 7,
   parameter logic [KEY_W-1:0] KEY_IDLE = '1,
   localparam int              DUR_W    = CNT_W + 1,
   localparam int              PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_clear,
   input  logic             evt_valid,
   input  logic [KEY_W-1:0] evt_code,
   input  logic             tick,
   input  logic             rd_req,
   input  logic             adv_req,
   output logic [KEY_W-1:0] rd_key,
   output logic [DUR_W-1:0] rd_dur,
   output logic             empty,
   output logic             int_n
);
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      initial $fatal(1, "key_event_fifo: DEPTH must be 2..256");
   end
   if (KEY_W < 1 || CNT_W < 1) begin : g_bad_width
      initial $fatal(1, "key_event_fifo: KEY_W and CNT_W must be positive");
   end

   logic [PTR_W-1:0] wr_ptr, wr_nxt, rd_ptr;
   logic [DUR_W-1:0] live_dur, live_dur_nxt;

   kef_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pd_clear),
      .evt    (evt_valid),
      .adv    (adv_req),
      .wr_ptr (wr_ptr),
      .wr_nxt (wr_nxt),
      .rd_ptr (rd_ptr),
      .empty  (empty)
   );

   kef_dur_step #(.CNT_W(CNT_W)) u_step (
      .cur (live_dur),
      .nxt (live_dur_nxt)
   );

   kef_slot_store #(
      .DEPTH    (DEPTH),
      .KEY_W    (KEY_W),
      .CNT_W    (CNT_W),
      .KEY_IDLE (KEY_IDLE)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (pd_clear),
      .evt          (evt_valid),
      .evt_code     (evt_code),
      .tick         (tick),
      .wr_ptr       (wr_ptr),
      .wr_nxt       (wr_nxt),
      .rd_ptr       (rd_ptr),
      .live_dur_nxt (live_dur_nxt),
      .live_dur     (live_dur),
      .rd_key       (rd_key),
      .rd_dur       (rd_dur)
   );

   kef_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pd_clear),
      .evt   (evt_valid),
      .ack   (rd_req),
      .int_n (int_n)
   );
endmodule

// File: rtl/key_event_fifo_chk.sv
module key_event_fifo_chk #(
   parameter int KEY_W = 8,
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_clear,
   input logic             evt_valid,
   input logic             tick,
   input logic             rd_req,
   input logic             adv_req,
   input logic [KEY_W-1:0] rd_key,
   input logic [CNT_W:0]   rd_dur,
   input logic             empty,
   input logic             int_n
);
   // R10
   clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_clear |=> (empty && int_n && rd_dur == '0));

   // R4
   event_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !pd_clear) |=> (!int_n && !empty));

   // R5
   read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !evt_valid && !pd_clear) |=> int_n);

   // R5
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && evt_valid && !pd_clear) |=> !int_n);

   // R9
   quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_valid && !pd_clear && !tick && !adv_req)
      |=> ($stable(rd_key) && $stable(rd_dur)));

   // R3
   sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dur[CNT_W] && !evt_valid && !pd_clear && !adv_req) |=> rd_dur[CNT_W]);

   // R6
   adv_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && adv_req && !evt_valid && !pd_clear) |=> (empty && $stable(rd_key)));
endmodule

bind key_event_fifo key_event_fifo_chk #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pd_clear  (pd_clear),
   .evt_valid (evt_valid),
   .tick      (tick),
   .rd_req    (rd_req),
   .adv_req   (adv_req),
   .rd_key    (rd_key),
   .rd_dur    (rd_dur),
   .empty     (empty),
   .int_n     (int_n)
);

// File: tb/key_event_fifo_tb.sv
`timescale 1ns/1ps
module key_event_fifo_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pd_clear = 1'b0;
   logic       evt_valid = 1'b0;
   logic [7:0] evt_code = 8'h00;
   logic       tick = 1'b0;
   logic       rd_req = 1'b0;
   logic       adv_req = 1'b0;
   logic [7:0] rd_key;
   logic [7:0] rd_dur;
   logic       empty;
   logic       int_n;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   key_event_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .pd_clear(pd_clear),
      .evt_valid(evt_valid), .evt_code(evt_code), .tick(tick),
      .rd_req(rd_req), .adv_req(adv_req),
      .rd_key(rd_key), .rd_dur(rd_dur), .empty(empty), .int_n(int_n)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%02h expected=0x%02h", req, what, act, exp);
      end
   endtask

   task automatic do_event(input logic [7:0] code);
      evt_valid = 1'b1; evt_code = code;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic do_read();
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic do_adv();
      adv_req = 1'b1;
      @(negedge clk);
      adv_req = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "key", rd_key, 8'hFF);
      check("R1", "dur", rd_dur, 8'h00);
      check("R1", "empty", {7'd0, empty}, 8'h01);
      check("R1", "int_n", {7'd0, int_n}, 8'h01);
   endtask

   task automatic t_count();
      do_ticks(5);
      check("R2", "live dur after 5 ticks", rd_dur, 8'h05);
   endtask

   task automatic t_event();
      do_event(8'h11);
      check("R4", "closed key", rd_key, 8'hFF);
      check("R4", "closed dur", rd_dur, 8'h05);
      check("R4", "int_n", {7'd0, int_n}, 8'h00);
      check("R4", "empty", {7'd0, empty}, 8'h00);
      do_ticks(3);
      check("R9", "closed dur frozen", rd_dur, 8'h05);
      do_read();
      check("R5", "int_n after read", {7'd0, int_n}, 8'h01);
   endtask

   task automatic t_advance();
      do_adv();
      check("R6", "live key", rd_key, 8'h11);
      check("R6", "live dur", rd_dur, 8'h03);
      check("R6", "empty", {7'd0, empty}, 8'h01);
      do_adv();
      check("R6", "ignored adv key", rd_key, 8'h11);
      check("R6", "ignored adv empty", {7'd0, empty}, 8'h01);
      do_ticks(2);
      check("R2", "live dur visible", rd_dur, 8'h05);
   endtask

   task automatic t_overflow();
      do_ticks(122);
      check("R3", "count at top", rd_dur, 8'h7F);
      do_ticks(1);
      check("R3", "wrap sets flag", rd_dur, 8'h80);
      do_ticks(3);
      check("R3", "flag sticky", rd_dur, 8'h83);
   endtask

   task automatic t_event_read_same();
      rd_req = 1'b1; evt_valid = 1'b1; evt_code = 8'h22;
      @(negedge clk);
      rd_req = 1'b0; evt_valid = 1'b0;
      check("R5", "event beats read", {7'd0, int_n}, 8'h00);
      check("R4", "closed key kept", rd_key, 8'h11);
      check("R3", "closed dur kept", rd_dur, 8'h83);
      do_read();
      check("R5", "read alone", {7'd0, int_n}, 8'h01);
   endtask

   task automatic t_full_wrap();
      pd_clear = 1'b1;
      @(negedge clk);
      pd_clear = 1'b0;
      check("R10", "clear key", rd_key, 8'hFF);
      check("R10", "clear empty", {7'd0, empty}, 8'h01);
      for (int k = 1; k <= 7; k++) do_event(8'(k));
      check("R7", "oldest before overwrite", rd_key, 8'hFF);
      do_event(8'h08);
      check("R7", "next oldest after overwrite", rd_key, 8'h01);
      check("R7", "not empty", {7'd0, empty}, 8'h00);
      for (int k = 0; k < 6; k++) do_adv();
      check("R8", "last slot key", rd_key, 8'h07);
      do_adv();
      check("R8", "wrapped to slot 0 key", rd_key, 8'h08);
      check("R8", "empty after wrap", {7'd0, empty}, 8'h01);
   endtask

   task automatic t_clear();
      do_event(8'h33);
      do_ticks(2);
      pd_clear = 1'b1; evt_valid = 1'b1; evt_code = 8'h44; tick = 1'b1;
      @(negedge clk);
      pd_clear = 1'b0; evt_valid = 1'b0; tick = 1'b0;
      check("R10", "key", rd_key, 8'hFF);
      check("R10", "dur", rd_dur, 8'h00);
      check("R10", "int_n", {7'd0, int_n}, 8'h01);
      check("R10", "empty", {7'd0, empty}, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_event();
      t_advance();
      t_overflow();
      t_event_read_same();
      t_full_wrap();
      t_clear();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule